// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block sends words over a single serial data pin, most significant bit first. Each transfer starts on a frame sync pulse. It runs on one clock, and that clock is the bit clock: one bit leaves per cycle. Software-side logic writes one word at a time into a holding register. The block copies that word into a shift register when the word is needed. A ready flag tells the writer when the holding register can take the next word. The flag rises one bit clock after the copy, which stands for the falling edge that follows the copy.

A frame holds a programmable number of words, and every word has the same programmable length. The words of a frame go out back to back with no gap. A frame sync that arrives during the last bit of a frame starts the next frame at once. The shortest frame-sync spacing is therefore the number of bits in a frame, and the frame rate is the bit rate divided by the number of bit clocks between syncs. A data delay of 0, 1 or 2 bit clocks can be placed between the sync and the first bit. While no frame is being sent, the pin sits at a programmable idle level. If no new word is waiting when one is needed, the previous word goes out again and a sticky underrun flag is raised.

Top module: `tx_framer`

## Requirements
- R1: After reset, `tx_ready` is 1, `underrun` is 0 and `dout` is at the idle level set by `cfg_idle`.
- R2: With a data delay of 0, a frame sync sampled at a clock edge puts bit `cfg_wlen` of the first word on `dout` right after that edge. The remaining bits follow MSB first, one per cycle, so a word has `cfg_wlen`+1 bits.
- R3: With `cfg_delay` = d (1 or 2), `dout` stays at the idle level for d cycles after the sync edge, then the first bit appears. A code of 3 behaves like 2.
- R4: A frame carries `cfg_nwords`+1 words sent back to back with no gap between words. Frames of 10 words of 16 bits are supported.
- R5: A frame sync is accepted only when no frame is in progress or during the last bit of a frame. Accepting it in the last bit starts the next frame with no idle cycle. A sync seen at any other time has no effect on `dout`.
- R6: `tx_ready` goes low in the cycle after a write (`wr_en`=1). It goes high one cycle after the cycle in which the holding register was emptied by a copy into the shift register, unless a new write arrives first.
- R7: If the holding register is empty when a word is needed, the last word loaded into the shift register is sent again and `underrun` goes to 1. It stays 1 until `underrun_clr` is pulsed.
- R8: Outside a frame and during the data delay, `dout` equals `cfg_idle`, for both levels.
- R9: A second write before the holding register is copied replaces the earlier data, so the last written word is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit is sent per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_delay | input | 2 | Data delay in bit clocks (0, 1, 2; 3 acts as 2) |
| cfg_wlen | input | 4 | Word length minus one |
| cfg_nwords | input | 4 | Words per frame minus one |
| cfg_idle | input | 1 | Level driven on `dout` outside frames |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Word written into the holding register (low `cfg_wlen`+1 bits used) |
| tx_ready | output | 1 | Holding register may be written |
| underrun | output | 1 | Sticky flag: a word was re-sent because no new word was waiting |
| underrun_clr | input | 1 | Clears `underrun` |
| fsync | input | 1 | Frame sync, sampled on each clock edge |
| dout | output | 1 | Serial data output |

## Verification
The bound checker watches the ready handshake, holding-register fill, underrun stickiness and the choice between delay wait and immediate shifting on every cycle. Several things depend on whole sequences and can only be shown by the bench scenarios: the serial bit order, gap-free word chaining, back-to-back frames, rejection of a sync in mid-frame, and the value that is re-sent on underrun. The bench predicts the full `dout` stream from the written words and the settings, and compares it bit by bit.

// File: rtl/tx_frm_pkg.sv
package tx_frm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DLY   = 2'd1,
      ST_SHIFT = 2'd2
   } seq_st_t;

   function automatic logic [1:0] clamp_delay(input logic [1:0] req, input int unsigned max_dly);
      logic [1:0] lim;
      lim = 2'(max_dly);
      return (req > lim) ? lim : req;
   endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          take,
   output logic [DW-1:0] hold_q,
   output logic          full_q,
   output logic          rdy_q
);

   logic take_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         take_d <= 1'b0;
         rdy_q  <= 1'b1;
      end else begin
         take_d <= take;
         if (wr_en) begin
            hold_q <= wr_data;
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
         // ready rises one bit clock after the copy, unless refilled
         if (wr_en)
            rdy_q <= 1'b0;
         else if (take_d && !full_q)
            rdy_q <= 1'b1;
      end
   end

endmodule

// File: rtl/tx_seq.sv
module tx_seq
   import tx_frm_pkg::*;
#(
   parameter int unsigned MAX_W     = 16,
   parameter int unsigned MAX_WORDS = 16,
   localparam int unsigned WL_W     = $clog2(MAX_W),
   localparam int unsigned NW_W     = $clog2(MAX_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic [1:0]       dly,
   input  logic [WL_W-1:0]  wlen,
   input  logic [NW_W-1:0]  nwords,
   input  logic [MAX_W-1:0] hold_q,
   input  logic             full_q,
   output logic             take,
   output logic             starve,
   output logic             accept,
   output logic             bit_q,
   output seq_st_t          state_q
);

   logic [MAX_W-1:0] sr_q;
   logic [WL_W-1:0]  bidx_q;
   logic [NW_W-1:0]  widx_q;
   logic [1:0]       dcnt_q;
   logic             word_end, frame_end, next_word, need;
   logic [MAX_W-1:0] nxt_word;
   logic [WL_W-1:0]  bidx_dn;

   assign word_end  = (state_q == ST_SHIFT) && (bidx_q == '0);
   assign frame_end = word_end && (widx_q == nwords);
   assign accept    = fsync && ((state_q == ST_IDLE) || frame_end);
   assign next_word = word_end && !frame_end;
   assign need      = accept || next_word;
   assign take      = need && full_q;
   assign starve    = need && !full_q;
   assign nxt_word  = full_q ? hold_q : sr_q;
   assign bidx_dn   = bidx_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sr_q    <= '0;
         bidx_q  <= '0;
         widx_q  <= '0;
         dcnt_q  <= '0;
         bit_q   <= 1'b0;
      end else if (accept) begin
         sr_q   <= nxt_word;
         widx_q <= '0;
         if (dly == 2'd0) begin
            bit_q   <= nxt_word[wlen];
            bidx_q  <= wlen;
            state_q <= ST_SHIFT;
         end else begin
            dcnt_q  <= dly - 2'd1;
            state_q <= ST_DLY;
         end
      end else begin
         unique case (state_q)
            ST_DLY: begin
               if (dcnt_q == 2'd0) begin
                  bit_q   <= sr_q[wlen];
                  bidx_q  <= wlen;
                  state_q <= ST_SHIFT;
               end else begin
                  dcnt_q <= dcnt_q - 2'd1;
               end
            end
            ST_SHIFT: begin
               if (next_word) begin
                  sr_q   <= nxt_word;
                  bit_q  <= nxt_word[wlen];
                  bidx_q <= wlen;
                  widx_q <= widx_q + 1'b1;
               end else if (frame_end) begin
                  state_q <= ST_IDLE;
               end else begin
                  bidx_q <= bidx_dn;
                  bit_q  <= sr_q[bidx_dn];
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tx_framer.sv
module tx_framer
   import tx_frm_pkg::*;
#(
   parameter int unsigned MAX_W     = 16,
   parameter int unsigned MAX_WORDS = 16,
   parameter int unsigned MAX_DLY   = 2,
   localparam int unsigned WL_W     = $clog2(MAX_W),
   localparam int unsigned NW_W     = $clog2(MAX_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_delay,
   input  logic [WL_W-1:0]  cfg_wlen,
   input  logic [NW_W-1:0]  cfg_nwords,
   input  logic             cfg_idle,
   input  logic             wr_en,
   input  logic [MAX_W-1:0] wr_data,
   output logic             tx_ready,
   output logic             underrun,
   input  logic             underrun_clr,
   input  logic             fsync,
   output logic             dout
);

   generate
      if (MAX_W < 2) begin : g_bad_w
         $error("tx_framer: MAX_W must be at least 2");
      end
      if (MAX_WORDS < 2) begin : g_bad_n
         $error("tx_framer: MAX_WORDS must be at least 2");
      end
      if (MAX_DLY > 2) begin : g_bad_d
         $error("tx_framer: MAX_DLY must be 0, 1 or 2");
      end
   endgenerate

   logic [MAX_W-1:0] hold_w;
   logic             full_w, take_w, starve_w, accept_w, bit_w;
   logic [1:0]       dly_w;
   seq_st_t          st_w;

   generate
      if (MAX_DLY == 0) begin : g_no_dly
         assign dly_w = 2'd0;
      end else begin : g_dly
         assign dly_w = clamp_delay(cfg_delay, MAX_DLY);
      end
   endgenerate

   tx_hold_buf #(.DW(MAX_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take_w),
      .hold_q  (hold_w),
      .full_q  (full_w),
      .rdy_q   (tx_ready)
   );

   tx_seq #(.MAX_W(MAX_W), .MAX_WORDS(MAX_WORDS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .fsync   (fsync),
      .dly     (dly_w),
      .wlen    (cfg_wlen),
      .nwords  (cfg_nwords),
      .hold_q  (hold_w),
      .full_q  (full_w),
      .take    (take_w),
      .starve  (starve_w),
      .accept  (accept_w),
      .bit_q   (bit_w),
      .state_q (st_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         underrun <= 1'b0;
      else if (starve_w)
         underrun <= 1'b1;
      else if (underrun_clr)
         underrun <= 1'b0;
   end

   assign dout = (st_w == ST_SHIFT) ? bit_w : cfg_idle;

endmodule

// File: rtl/tx_frm_chk.sv
module tx_frm_chk
   import tx_frm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       tx_ready,
   input logic       underrun,
   input logic       underrun_clr,
   input logic       hold_full,
   input logic       accept,
   input logic [1:0] dly,
   input seq_st_t    state
);

   AST_RDY_CLR_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tx_ready); // R6

   AST_RDY_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hold_full) && !wr_en) |=> tx_ready); // R6

   AST_WR_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> hold_full); // R9

   AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !underrun_clr) |=> underrun); // R7

   AST_DLY0_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dly == 2'd0) |=> state == ST_SHIFT); // R2

   AST_DLYN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dly != 2'd0) |=> state == ST_DLY); // R3

endmodule

bind tx_framer tx_frm_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .tx_ready     (tx_ready),
   .underrun     (underrun),
   .underrun_clr (underrun_clr),
   .hold_full    (full_w),
   .accept       (accept_w),
   .dly          (dly_w),
   .state        (st_w)
);

// File: tb/tx_framer_tb_top.sv
module tx_framer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_delay = 2'd0;
   logic [3:0]  cfg_wlen = 4'd15;
   logic [3:0]  cfg_nwords = 4'd0;
   logic        cfg_idle = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        underrun_clr = 1'b0;
   logic        fsync = 1'b0;
   logic        tx_ready, underrun, dout;

   int nvec = 0;
   int nfail = 0;

   logic        exp_q[$];
   string       tag_q[$];
   logic [15:0] frm_q[$];
   logic [15:0] wrl_q[$];

   always #5 clk = ~clk;

   tx_framer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_delay), .cfg_wlen(cfg_wlen),
      .cfg_nwords(cfg_nwords), .cfg_idle(cfg_idle), .wr_en(wr_en), .wr_data(wr_data),
      .tx_ready(tx_ready), .underrun(underrun), .underrun_clr(underrun_clr),
      .fsync(fsync), .dout(dout)
   );

   task automatic check(input string req, input logic act, input logic expv, input string what);
      nvec++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, expv, $time);
      end
   endtask

   // monitor: pops one expected dout value per cycle, shortly after the edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, dout, e, "dout");
      end
   end

   // called at a negedge; pushes idle expectations and waits
   task automatic idle_cycles(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(cfg_idle);
         tag_q.push_back(req);
         @(negedge clk);
      end
   endtask

   // called at a negedge; returns at the negedge before the last-bit edge
   task automatic run_frame(input int d, input int nw, input int gl, input string req);
      int L;
      L = int'(cfg_wlen) + 1;
      fsync = 1'b1;
      for (int i = 0; i < d; i++) begin
         exp_q.push_back(cfg_idle);
         tag_q.push_back(req);
      end
      for (int w = 0; w < nw; w++) begin
         logic [15:0] v;
         v = frm_q.pop_front();
         for (int b = L - 1; b >= 0; b--) begin
            exp_q.push_back(v[b]);
            tag_q.push_back(req);
         end
      end
      for (int c = 0; c < d + L * nw; c++) begin
         @(negedge clk);
         fsync = (gl > 0 && c == gl) ? 1'b1 : 1'b0;
      end
   endtask

   task automatic cpu_write(input logic [15:0] v);
      while (!tx_ready) @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic writer_all();
      while (wrl_q.size() > 0) cpu_write(wrl_q.pop_front());
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", tx_ready, 1'b1, "tx_ready in reset");
      check("R1", underrun, 1'b0, "underrun in reset");
      check("R1", dout, 1'b1, "dout in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", tx_ready, 1'b1, "tx_ready after reset");
      idle_cycles(2, "R8");

      // R2: one 16-bit word, no delay
      cpu_write(16'hA5C3);
      frm_q.push_back(16'hA5C3);
      run_frame(0, 1, 0, "R2");
      idle_cycles(3, "R8");

      // R3: delays 1, 2 and code 3 acting as 2
      for (int dc = 1; dc <= 3; dc++) begin
         logic [15:0] v;
         v = 16'h3C01 ^ 16'(dc * 16'h1111);
         cfg_delay = 2'(dc);
         cpu_write(v);
         frm_q.push_back(v);
         run_frame((dc > 2) ? 2 : dc, 1, 0, "R3");
         idle_cycles(2, "R3");
      end
      cfg_delay = 2'd0;

      // R4/R5: two back-to-back frames of 10 x 16-bit words
      cfg_nwords = 4'd9;
      for (int i = 0; i < 20; i++) begin
         logic [15:0] v;
         v = 16'((i * 16'h2B47) ^ 16'h81E5);
         frm_q.push_back(v);
         if (i > 0) wrl_q.push_back(v);
         else cpu_write(v);
      end
      fork
         writer_all();
         begin
            run_frame(0, 10, 0, "R4");
            run_frame(0, 10, 0, "R5");
         end
      join
      idle_cycles(2, "R5");

      // R5: sync in mid-frame is ignored (8-bit words, 2 per frame)
      cfg_wlen = 4'd7;
      cfg_nwords = 4'd1;
      cpu_write(16'h00D2);
      frm_q.push_back(16'h00D2);
      frm_q.push_back(16'h004B);
      wrl_q.push_back(16'h004B);
      fork
         writer_all();
         run_frame(0, 2, 5, "R5");
      join
      idle_cycles(3, "R5");

      // R6: ready timing around write and copy
      cfg_nwords = 4'd0;
      cpu_write(16'h0096);
      check("R6", tx_ready, 1'b0, "tx_ready after write");
      frm_q.push_back(16'h0096);
      fork
         run_frame(0, 1, 0, "R6");
         begin
            @(posedge clk); #3;
            check("R6", tx_ready, 1'b0, "tx_ready in copy cycle");
            @(posedge clk); #3;
            check("R6", tx_ready, 1'b1, "tx_ready one cycle after copy");
         end
      join
      idle_cycles(2, "R8");

      // R7: underrun repeats last word and is sticky
      cfg_nwords = 4'd1;
      cpu_write(16'h00E7);
      frm_q.push_back(16'h00E7);
      frm_q.push_back(16'h00E7);
      run_frame(0, 2, 0, "R7");
      idle_cycles(4, "R7");
      check("R7", underrun, 1'b1, "underrun after starved word");
      underrun_clr = 1'b1;
      @(negedge clk);
      underrun_clr = 1'b0;
      check("R7", underrun, 1'b0, "underrun after clear");

      // R8: idle level low, 4-bit word
      cfg_idle = 1'b0;
      cfg_wlen = 4'd3;
      cfg_nwords = 4'd0;
      @(negedge clk);
      check("R8", dout, 1'b0, "dout idle low");
      cpu_write(16'h0009);
      frm_q.push_back(16'h0009);
      run_frame(0, 1, 0, "R8");
      idle_cycles(3, "R8");
      cfg_idle = 1'b1;

      // R9: second write before copy replaces data
      cfg_wlen = 4'd15;
      cpu_write(16'h1234);
      wr_en = 1'b1;
      wr_data = 16'hBEEF;
      @(negedge clk);
      wr_en = 1'b0;
      frm_q.push_back(16'hBEEF);
      run_frame(0, 1, 0, "R9");
      idle_cycles(2, "R9");
      check("R9", underrun, 1'b0, "no underrun after overwrite");

      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule